// File: doc/BRIEF.md
# Delayed-Branch Next-PC Sequencer

This block produces the fetch address of a single-issue core whose control transfers have one architectural delay slot. It holds two registers: the address of the instruction that is executing now, and the address of the one that follows it. On each clock both registers move forward. The first takes the old value of the second. The second takes either the sequential successor or a redirect target, which comes from the control-transfer kind decoded this cycle. As a result, the instruction that follows a branch or jump always runs, and a taken transfer changes the fetch stream one instruction later.

Each cycle the decoder gives the block a transfer kind, two register operands, a 16-bit word offset and a 26-bit jump field. The block can resolve branches that compare two operands for equality and branches that compare one operand with zero as a signed value. It also handles absolute jumps within the current 256 MB region and jumps through a register. The linking forms raise a combinational write request to register 31. That request carries the return address, which is the word after the delay slot. The register file write, the instruction memory and exceptions belong to other blocks.

Top module: `dslot_pc_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the executing address is reset to 0 and the following address to 4. In the cycle after reset, `fetch_pc` reads 0, and with no transfers it then reads 4, 8 and so on. During a cycle in which `rst` is high, `link_we` is 0.
- R2: Kind code 0 means no transfer. Codes 12 to 15 are unused and have the same effect. With either, `fetch_pc` advances by 4 on each clock.
- R3: When a transfer at address P is taken, `fetch_pc` reads P+4 (the delay slot) in the next cycle and the target in the cycle after that. When it is not taken, those two cycles read P+4 and then P+8.
- R4: Code 1 is taken when `opnd_a` equals `opnd_b`. Code 2 is taken when they differ.
- R5: These codes test `opnd_a` as a two's-complement value against zero: code 3 (less than or equal), code 4 (greater than), code 5 (less than), code 6 (greater than or equal).
- R6: A taken branch goes to the delay-slot address plus `br_offset` sign-extended and multiplied by 4. Negative offsets are included.
- R7: Codes 9 (jump) and 10 (jump and link) are always taken. Their target is the top 4 bits of the delay-slot address, followed by `jump_field`, followed by two zero bits.
- R8: Code 11 is always taken, and its target is `opnd_a` unchanged.
- R9: Code 7 (less than zero, linking), code 8 (greater than or equal to zero, linking) and code 10 drive `link_we` high, `link_idx` to 31 and `link_val` to the executing address plus 8. This happens in the same cycle as the transfer and does not depend on whether the branch is taken.
- R10: Every code other than 7, 8 and 10 leaves `link_we` low.
- R11: A taken transfer in the delay slot of another taken transfer computes its target from the first target. The fetch sequence is P, P+4, T1, T2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_kind | input | 4 | Decoded control-transfer kind of the executing instruction |
| opnd_a | input | 32 | First register operand; also the register-jump target |
| opnd_b | input | 32 | Second register operand for the equality compares |
| br_offset | input | 16 | Signed branch offset in words |
| jump_field | input | 26 | Word index of the absolute jump target |
| fetch_pc | output | 32 | Address of the executing instruction |
| link_we | output | 1 | Request to write the return address |
| link_idx | output | 5 | Destination register of the link write |
| link_val | output | 32 | Return address |

## Verification
The bench builds the block with its default parameters: a 32-bit address, 4-byte instructions, a 16-bit offset, a 26-bit jump field and register 31 as the link target. These values leave a 4-bit region field, so a register jump into the top region followed by an absolute jump shows whether the region bits come from the delay slot. With the sign bit at position 31, operands of 0x80000000 and 0xFFFFFFFF test the signed zero-compares at their edges. A 16-bit offset of 0xFFFF gives a branch whose target falls back onto its own address.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    typedef enum logic [3:0] {
        XF_NONE     = 4'd0,
        XF_BR_EQ    = 4'd1,
        XF_BR_NE    = 4'd2,
        XF_BR_LEZ   = 4'd3,
        XF_BR_GTZ   = 4'd4,
        XF_BR_LTZ   = 4'd5,
        XF_BR_GEZ   = 4'd6,
        XF_BR_LTZ_L = 4'd7,
        XF_BR_GEZ_L = 4'd8,
        XF_JMP      = 4'd9,
        XF_JMP_L    = 4'd10,
        XF_JMP_REG  = 4'd11
    } xfer_e;

    typedef enum logic [1:0] {
        TGT_SEQ  = 2'd0,
        TGT_REL  = 2'd1,
        TGT_ABS  = 2'd2,
        TGT_REG  = 2'd3
    } tgt_src_e;

    function automatic logic kind_links(xfer_e k);
        return (k == XF_BR_LTZ_L) || (k == XF_BR_GEZ_L) || (k == XF_JMP_L);
    endfunction

    function automatic tgt_src_e kind_source(xfer_e k);
        case (k)
            XF_BR_EQ, XF_BR_NE, XF_BR_LEZ, XF_BR_GTZ,
            XF_BR_LTZ, XF_BR_GEZ, XF_BR_LTZ_L, XF_BR_GEZ_L: return TGT_REL;
            XF_JMP, XF_JMP_L:                              return TGT_ABS;
            XF_JMP_REG:                                    return TGT_REG;
            default:                                       return TGT_SEQ;
        endcase
    endfunction

endpackage

// File: rtl/pcseq_cond.sv
module pcseq_cond
    import pcseq_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  xfer_e             kind,
    input  logic [XLEN-1:0]   opnd_a,
    input  logic [XLEN-1:0]   opnd_b,
    output logic              taken
);

    logic same;
    logic is_neg;
    logic is_zero;

    always_comb begin
        same    = (opnd_a == opnd_b);
        is_neg  = opnd_a[XLEN-1];
        is_zero = (opnd_a == '0);
    end

    always_comb begin
        case (kind)
            XF_BR_EQ:                  taken = same;
            XF_BR_NE:                  taken = !same;
            XF_BR_LEZ:                 taken = is_neg || is_zero;
            XF_BR_GTZ:                 taken = !is_neg && !is_zero;
            XF_BR_LTZ, XF_BR_LTZ_L:    taken = is_neg;
            XF_BR_GEZ, XF_BR_GEZ_L:    taken = !is_neg;
            XF_JMP, XF_JMP_L,
            XF_JMP_REG:                taken = 1'b1;
            default:                   taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/pcseq_target.sv
module pcseq_target
    import pcseq_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter int OFS_W       = 16,
    parameter int FIELD_W     = 26,
    parameter int INSTR_BYTES = 4
) (
    input  xfer_e              kind,
    input  logic [XLEN-1:0]    slot_pc,
    input  logic [XLEN-1:0]    opnd_a,
    input  logic [OFS_W-1:0]   br_offset,
    input  logic [FIELD_W-1:0] jump_field,
    output logic [XLEN-1:0]    target
);

    localparam int SH       = $clog2(INSTR_BYTES);
    localparam int REGION_W = XLEN - FIELD_W - SH;

    logic [XLEN-1:0] ofs_ext;
    logic [XLEN-1:0] rel_tgt;
    logic [XLEN-1:0] abs_tgt;
    tgt_src_e        src;

    always_comb begin
        ofs_ext = {{(XLEN-OFS_W){br_offset[OFS_W-1]}}, br_offset};
        rel_tgt = slot_pc + (ofs_ext << SH);
        src     = kind_source(kind);
    end

    generate
        if (REGION_W > 0) begin : g_region
            assign abs_tgt = {slot_pc[XLEN-1 -: REGION_W], jump_field, {SH{1'b0}}};
        end else begin : g_flat
            assign abs_tgt = XLEN'({jump_field, {SH{1'b0}}});
        end
    endgenerate

    always_comb begin
        case (src)
            TGT_REL: target = rel_tgt;
            TGT_ABS: target = abs_tgt;
            TGT_REG: target = opnd_a;
            default: target = slot_pc + XLEN'(INSTR_BYTES);
        endcase
    end

endmodule

// File: rtl/dslot_pc_seq.sv
module dslot_pc_seq
    import pcseq_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter int OFS_W       = 16,
    parameter int FIELD_W     = 26,
    parameter int INSTR_BYTES = 4,
    parameter int REG_IDX_W   = 5,
    parameter int LINK_REG    = 31,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [3:0]           xfer_kind,
    input  logic [XLEN-1:0]      opnd_a,
    input  logic [XLEN-1:0]      opnd_b,
    input  logic [OFS_W-1:0]     br_offset,
    input  logic [FIELD_W-1:0]   jump_field,
    output logic [XLEN-1:0]      fetch_pc,
    output logic                 link_we,
    output logic [REG_IDX_W-1:0] link_idx,
    output logic [XLEN-1:0]      link_val
);

    localparam logic [XLEN-1:0] STEP  = XLEN'(INSTR_BYTES);
    localparam logic [XLEN-1:0] PC0   = XLEN'(RESET_PC);

    xfer_e           kind;
    logic            redirect;
    logic [XLEN-1:0] target;
    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] npc_q;
    logic [XLEN-1:0] npc_d;

    assign kind = xfer_e'(xfer_kind);

    pcseq_cond #(.XLEN(XLEN)) u_cond (
        .kind   (kind),
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .taken  (redirect)
    );

    pcseq_target #(
        .XLEN        (XLEN),
        .OFS_W       (OFS_W),
        .FIELD_W     (FIELD_W),
        .INSTR_BYTES (INSTR_BYTES)
    ) u_target (
        .kind       (kind),
        .slot_pc    (npc_q),
        .opnd_a     (opnd_a),
        .br_offset  (br_offset),
        .jump_field (jump_field),
        .target     (target)
    );

    always_comb begin
        npc_d = redirect ? target : (npc_q + STEP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= PC0;
            npc_q <= PC0 + STEP;
        end else begin
            pc_q  <= npc_q;
            npc_q <= npc_d;
        end
    end

    always_comb begin
        fetch_pc = pc_q;
        link_we  = !rst && kind_links(kind);
        link_idx = REG_IDX_W'(LINK_REG);
        link_val = pc_q + (STEP << 1);
    end

    // R1: reset loads the executing and following addresses
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (fetch_pc == PC0) && (npc_q == PC0 + STEP));

    // R2: no redirect means the following address moves by one word
    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        !redirect |=> npc_q == $past(npc_q) + STEP);

    // R3: a redirect outside a slot still fetches the delay slot next
    assert_slot_R3: assert property (@(posedge clk) disable iff (rst)
        (redirect && (npc_q == pc_q + STEP)) |=> fetch_pc == $past(fetch_pc) + STEP);

    // R5: negative operand takes the less-than-zero branch
    assert_ltz_R5: assert property (@(posedge clk) disable iff (rst)
        (kind == XF_BR_LTZ && opnd_a[XLEN-1]) |=> npc_q == $past(target));

    // R7: absolute jumps land on a word boundary
    assert_jump_align_R7: assert property (@(posedge clk) disable iff (rst)
        (kind == XF_JMP || kind == XF_JMP_L) |=> npc_q[1:0] == 2'b00);

    // R8: register jump goes to the operand value
    assert_jreg_R8: assert property (@(posedge clk) disable iff (rst)
        (kind == XF_JMP_REG) |=> npc_q == $past(opnd_a));

    // R9: link request names the link register and skips the slot
    assert_link_R9: assert property (@(posedge clk) disable iff (rst)
        (link_we && (npc_q == pc_q + STEP)) |->
            (link_idx == REG_IDX_W'(LINK_REG)) && (link_val == npc_q + STEP));

    // R10: non-linking kinds never request a write
    assert_nolink_R10: assert property (@(posedge clk) disable iff (rst)
        (kind != XF_BR_LTZ_L && kind != XF_BR_GEZ_L && kind != XF_JMP_L) |-> !link_we);

endmodule

// File: tb/test_dslot_pc_seq.sv
module test_dslot_pc_seq;

    typedef struct packed {
        logic [3:0]  k;
        logic [31:0] a;
        logic [31:0] b;
        logic [15:0] o;
        logic [25:0] f;
        logic        tk;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{4'd1,  32'd5,          32'd5, 16'h0010, 26'd0,        1'b1},
        '{4'd1,  32'd5,          32'd6, 16'h0010, 26'd0,        1'b0},
        '{4'd2,  32'd5,          32'd6, 16'hFFFF, 26'd0,        1'b1},
        '{4'd2,  32'd7,          32'd7, 16'h0010, 26'd0,        1'b0},
        '{4'd3,  32'd0,          32'd0, 16'h0003, 26'd0,        1'b1},
        '{4'd3,  32'd1,          32'd0, 16'h0003, 26'd0,        1'b0},
        '{4'd4,  32'h8000_0000,  32'd0, 16'h0020, 26'd0,        1'b0},
        '{4'd4,  32'd1,          32'd0, 16'h0020, 26'd0,        1'b1},
        '{4'd5,  32'hFFFF_FFFF,  32'd0, 16'h0002, 26'd0,        1'b1},
        '{4'd6,  32'd0,          32'd0, 16'h0005, 26'd0,        1'b1},
        '{4'd6,  32'h8000_0000,  32'd0, 16'h0005, 26'd0,        1'b0},
        '{4'd7,  32'd5,          32'd0, 16'h0009, 26'd0,        1'b0},
        '{4'd8,  32'd5,          32'd0, 16'h0009, 26'd0,        1'b1},
        '{4'd9,  32'd0,          32'd0, 16'h0000, 26'h100,      1'b1},
        '{4'd10, 32'd0,          32'd0, 16'h0000, 26'h3FF_FFFF, 1'b1},
        '{4'd11, 32'h0000_1234,  32'd0, 16'h0000, 26'd0,        1'b1},
        '{4'd0,  32'd5,          32'd5, 16'h0010, 26'h100,      1'b0},
        '{4'd13, 32'd5,          32'd5, 16'h0010, 26'h100,      1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  xfer_kind = 4'd0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [15:0] br_offset = '0;
    logic [25:0] jump_field = '0;
    logic [31:0] fetch_pc;
    logic        link_we;
    logic [4:0]  link_idx;
    logic [31:0] link_val;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #5 clk = ~clk;

    dslot_pc_seq i_dslot_pc_seq (
        .clk        (clk),
        .rst        (rst),
        .xfer_kind  (xfer_kind),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .br_offset  (br_offset),
        .jump_field (jump_field),
        .fetch_pc   (fetch_pc),
        .link_we    (link_we),
        .link_idx   (link_idx),
        .link_val   (link_val)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] k, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] o, input logic [25:0] f);
        xfer_kind  = k;
        opnd_a     = a;
        opnd_b     = b;
        br_offset  = o;
        jump_field = f;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        drive(4'd0, '0, '0, '0, '0);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [31:0] exp_target(vec_t v);
        case (v.k)
            4'd9, 4'd10: return {4'h0, v.f, 2'b00};
            4'd11:       return v.a;
            default:     return 32'd4 + {{14{v.o[15]}}, v.o, 2'b00};
        endcase
    endfunction

    initial begin
        // R1 reset state and sequential advance (R2)
        do_reset();
        #1;
        chk("R1 reset fetch", fetch_pc, 32'h0);
        chk("R1 reset link_we", {31'd0, link_we}, 32'd0);
        for (int i = 1; i <= 3; i++) begin
            @(negedge clk);
            #1;
            chk("R2 sequential", fetch_pc, 32'(4 * i));
        end

        // Vector table: R3..R10
        for (int v = 0; v < NV; v++) begin
            logic [31:0] tgt;
            logic        lk;
            do_reset();
            drive(VECS[v].k, VECS[v].a, VECS[v].b, VECS[v].o, VECS[v].f);
            lk  = (VECS[v].k == 4'd7) || (VECS[v].k == 4'd8) || (VECS[v].k == 4'd10);
            tgt = VECS[v].tk ? exp_target(VECS[v]) : 32'd8;
            #1;
            if (lk) begin
                chk("R9 link_we", {31'd0, link_we}, 32'd1);
                chk("R9 link_idx", {27'd0, link_idx}, 32'd31);
                chk("R9 link_val", link_val, 32'd8);
            end else begin
                chk("R10 no link", {31'd0, link_we}, 32'd0);
            end
            @(negedge clk);
            drive(4'd0, '0, '0, '0, '0);
            #1;
            chk("R3 delay slot", fetch_pc, 32'd4);
            @(negedge clk);
            #1;
            case (VECS[v].k)
                4'd1, 4'd2:        chk("R4 R6 equality branch", fetch_pc, tgt);
                4'd3, 4'd4, 4'd5,
                4'd6, 4'd7, 4'd8:  chk("R5 R6 zero-compare branch", fetch_pc, tgt);
                4'd9, 4'd10:       chk("R7 jump target", fetch_pc, tgt);
                4'd11:             chk("R8 register jump", fetch_pc, tgt);
                default:           chk("R2 no-transfer code", fetch_pc, tgt);
            endcase
        end

        // R7 region bits come from the delay slot; R9 link in high region
        do_reset();
        drive(4'd11, 32'hF000_0000, '0, '0, '0);
        @(negedge clk);
        drive(4'd0, '0, '0, '0, '0);
        @(negedge clk);
        #1;
        chk("R8 register jump high", fetch_pc, 32'hF000_0000);
        drive(4'd10, '0, '0, '0, 26'h10);
        #1;
        chk("R9 link_val high", link_val, 32'hF000_0008);
        @(negedge clk);
        drive(4'd0, '0, '0, '0, '0);
        #1;
        chk("R3 slot high", fetch_pc, 32'hF000_0004);
        @(negedge clk);
        #1;
        chk("R7 region jump", fetch_pc, 32'hF000_0040);

        // R11 taken transfer inside a delay slot
        do_reset();
        drive(4'd1, 32'd1, 32'd1, 16'h0010, '0);
        @(negedge clk);
        drive(4'd1, 32'd2, 32'd2, 16'h0020, '0);
        #1;
        chk("R11 first slot", fetch_pc, 32'd4);
        @(negedge clk);
        drive(4'd0, '0, '0, '0, '0);
        #1;
        chk("R11 first target", fetch_pc, 32'd68);
        @(negedge clk);
        #1;
        chk("R11 second target", fetch_pc, 32'd196);

        // R1 reset in mid-run
        @(negedge clk);
        rst = 1'b1;
        drive(4'd10, '0, '0, '0, 26'h55);
        #1;
        chk("R1 link held low in reset", {31'd0, link_we}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        drive(4'd0, '0, '0, '0, '0);
        #1;
        chk("R1 mid-run reset", fetch_pc, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule